// File: doc/BRIEF.md
# DMA Descriptor Validator and Status Packer

This block sits behind a descriptor fetch engine. Once a descriptor has been read from memory, its sixteen 32-bit words are streamed into the block, one word on each cycle where `in_valid` is high. Idle cycles may fall between words. While the words arrive, the block keeps the control word, the line geometry word and the timestamp word that carries the done flag. It also keeps a running 32-bit sum of every word except the final checksum word.

One cycle after the last word is accepted, the block raises a single-cycle result pulse. With the pulse it presents a verdict code and the decoded descriptor fields that the channel's software-visible registers need: the packed status word, the line size, the line stride in bytes, and a flag that ends the run. When write-back is enabled and the descriptor passed, it also presents a copy of the timestamp word with the done flag set. The result registers keep their values until the next descriptor completes.

The block makes no memory requests and moves no payload. Fetching descriptors and writing them back belong to the surrounding engine.

Top module: `desc_verifier`

## Requirements
- R1: `res_valid` is high for exactly one cycle, in the cycle after every sixteenth accepted word (counted over cycles with `in_valid` high, idle cycles allowed), and is low at all other times.
- R2: A descriptor whose control word (word 0) has a low byte other than 0xA5 is rejected with `res_err` = 1.
- R3: When control bit 20 is set, the 32-bit wrapping sum of words 0 to 14 must equal word 15, or `res_err` = 2. When control bit 20 is clear, word 15 has no effect on the verdict.
- R4: When bit 31 of word 5 (done flag) is set and control bit 10 (ignore-done) is clear, the descriptor is rejected with `res_err` = 3. With bit 10 set, the done flag causes no error.
- R5: The error code is 0 for a pass. When several checks fail, the code is chosen in priority order: preamble (1), then checksum (2), then already-done (3).
- R6: `res_last` is set when control bit 19 (end of chain) or bit 21 (end of frame) is set, whatever the verdict.
- R7: `res_line_size` equals word 3 bits 17:0. `res_stride` equals word 3 bits 31:18 multiplied by 16.
- R8: `res_status` holds control bits 7:0 at bits 20:13. It also holds control bit 11 at bit 4, bit 18 at bit 5, bit 20 at bit 6, bit 19 at bit 7, bit 21 at bit 8, bit 10 at bit 9, word 5 bit 31 at bit 10, control bit 9 at bit 11 and control bit 8 at bit 12. All other bits are zero.
- R9: `res_wb_req` is set only when control bit 9 is set and `res_err` is 0. `res_wb_word` always equals word 5 with bit 31 forced to 1.
- R10: After reset every result output is zero. Between result pulses all result outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A descriptor word is present on in_word |
| in_word | input | 32 | Descriptor word, word 0 first |
| res_valid | output | 1 | One-cycle result pulse |
| res_err | output | 2 | 0 pass, 1 preamble, 2 checksum, 3 already done |
| res_last | output | 1 | Run ends after this descriptor |
| res_status | output | 32 | Packed channel status word |
| res_line_size | output | 18 | Line size in bytes |
| res_stride | output | 18 | Line stride in bytes |
| res_wb_req | output | 1 | Write-back of the done-marked word requested |
| res_wb_word | output | 32 | Word 5 with the done flag set |

## Verification
The hardest conditions to reach are those where several checks fail at once, and where a checksum matches exactly while the sum wraps past 32 bits. Uniform random words almost never produce a valid preamble together with a matching checksum. For that reason the stimulus forces the preamble most of the time, computes word 15 from the other words on most checksum-enabled descriptors, and sets the done and ignore bits independently. Directed descriptors add the case where every check fails, a checksum built from near-maximum words, and a deliberately wrong word 15 while checking is disabled. Random idle gaps between words test that the word count stays aligned.

// File: rtl/desc_pkg.sv
package desc_pkg;
   typedef enum logic [1:0] {
      ERR_NONE     = 2'd0,
      ERR_PREAMBLE = 2'd1,
      ERR_CSUM     = 2'd2,
      ERR_DONE     = 2'd3
   } desc_err_e;

   // word positions inside the descriptor
   localparam int W_CTRL = 0;
   localparam int W_GEOM = 3;
   localparam int W_TIME = 5;

   // control word bit positions
   localparam int CB_IRQ    = 8;
   localparam int CB_UPDATE = 9;
   localparam int CB_IGNORE = 10;
   localparam int CB_BURST  = 11;
   localparam int CB_MODE   = 18;
   localparam int CB_LAST   = 19;
   localparam int CB_CSUM   = 20;
   localparam int CB_LFRAME = 21;
   localparam int DONE_BIT  = 31;

   // status word bit positions
   localparam int ST_BURST  = 4;
   localparam int ST_MODE   = 5;
   localparam int ST_CSUM   = 6;
   localparam int ST_LAST   = 7;
   localparam int ST_LFRAME = 8;
   localparam int ST_IGNORE = 9;
   localparam int ST_DONE   = 10;
   localparam int ST_UPDATE = 11;
   localparam int ST_IRQ    = 12;
   localparam int ST_PRE_LO = 13;
endpackage

// File: rtl/desc_word_track.sv
module desc_word_track #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              final_word,
   output logic [WORD_W-1:0] ctrl_q,
   output logic [WORD_W-1:0] geom_q,
   output logic [WORD_W-1:0] time_q
);
   import desc_pkg::*;
   localparam int IDX_W = $clog2(NUM_WORDS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

   logic [IDX_W-1:0] idx_q;

   assign final_word = (idx_q == IDX_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (in_valid) begin
         idx_q <= final_word ? '0 : idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         geom_q <= '0;
         time_q <= '0;
      end else if (in_valid) begin
         if (idx_q == IDX_W'(W_CTRL)) ctrl_q <= in_word;
         if (idx_q == IDX_W'(W_GEOM)) geom_q <= in_word;
         if (idx_q == IDX_W'(W_TIME)) time_q <= in_word;
      end
   end
endmodule

// File: rtl/desc_csum_acc.sv
module desc_csum_acc #(
   parameter int WORD_W  = 32,
   parameter bit CSUM_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              final_word,
   output logic              csum_match
);
   generate
      if (CSUM_EN) begin : g_sum
         logic [WORD_W-1:0] sum_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sum_q <= '0;
            end else if (in_valid) begin
               sum_q <= final_word ? '0 : sum_q + in_word;
            end
         end
         assign csum_match = (sum_q == in_word);
      end else begin : g_nosum
         logic unused_sum_in;
         assign unused_sum_in = ^{clk, rst_n, in_valid, in_word, final_word};
         assign csum_match = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/desc_judge.sv
module desc_judge #(
   parameter int         WORD_W       = 32,
   parameter int         SIZE_W       = 18,
   parameter int         STRIDE_W     = 14,
   parameter int         STRIDE_SHIFT = 4,
   parameter logic [7:0] PREAMBLE     = 8'hA5
) (
   input  logic [WORD_W-1:0]              ctrl,
   input  logic [WORD_W-1:0]              geom,
   input  logic [WORD_W-1:0]              stamp,
   input  logic                           csum_match,
   output desc_pkg::desc_err_e            err,
   output logic                           last,
   output logic [WORD_W-1:0]              status,
   output logic [SIZE_W-1:0]              line_size,
   output logic [STRIDE_W+STRIDE_SHIFT-1:0] stride,
   output logic                           wb_req,
   output logic [WORD_W-1:0]              wb_word
);
   import desc_pkg::*;

   logic pre_bad, csum_bad, done_bad;
   logic unused_ctrl_bits;

   assign pre_bad  = (ctrl[7:0] != PREAMBLE);
   assign csum_bad = ctrl[CB_CSUM] && !csum_match;
   assign done_bad = stamp[DONE_BIT] && !ctrl[CB_IGNORE];

   always_comb begin
      if (pre_bad)       err = ERR_PREAMBLE;
      else if (csum_bad) err = ERR_CSUM;
      else if (done_bad) err = ERR_DONE;
      else               err = ERR_NONE;
   end

   assign last = ctrl[CB_LAST] | ctrl[CB_LFRAME];

   always_comb begin
      status                      = '0;
      status[ST_PRE_LO +: 8]      = ctrl[7:0];
      status[ST_BURST]            = ctrl[CB_BURST];
      status[ST_MODE]             = ctrl[CB_MODE];
      status[ST_CSUM]             = ctrl[CB_CSUM];
      status[ST_LAST]             = ctrl[CB_LAST];
      status[ST_LFRAME]           = ctrl[CB_LFRAME];
      status[ST_IGNORE]           = ctrl[CB_IGNORE];
      status[ST_DONE]             = stamp[DONE_BIT];
      status[ST_UPDATE]           = ctrl[CB_UPDATE];
      status[ST_IRQ]              = ctrl[CB_IRQ];
   end

   assign line_size = geom[SIZE_W-1:0];
   assign stride    = {geom[WORD_W-1 -: STRIDE_W], {STRIDE_SHIFT{1'b0}}};

   assign wb_req  = ctrl[CB_UPDATE] && (err == ERR_NONE);
   assign wb_word = stamp | (WORD_W'(1) << DONE_BIT);

   assign unused_ctrl_bits = ^{ctrl[17:12], ctrl[WORD_W-1:22]};
endmodule

// File: rtl/desc_verifier.sv
module desc_verifier #(
   parameter int         WORD_W       = 32,
   parameter int         NUM_WORDS    = 16,
   parameter int         SIZE_W       = 18,
   parameter int         STRIDE_W     = 14,
   parameter int         STRIDE_SHIFT = 4,
   parameter logic [7:0] PREAMBLE     = 8'hA5,
   parameter bit         CSUM_EN      = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   input  logic [WORD_W-1:0]                in_word,
   output logic                             res_valid,
   output logic [1:0]                       res_err,
   output logic                             res_last,
   output logic [WORD_W-1:0]                res_status,
   output logic [SIZE_W-1:0]                res_line_size,
   output logic [STRIDE_W+STRIDE_SHIFT-1:0] res_stride,
   output logic                             res_wb_req,
   output logic [WORD_W-1:0]                res_wb_word
);
   import desc_pkg::*;
   localparam int STRIDE_OUT_W = STRIDE_W + STRIDE_SHIFT;

   initial begin
      if (WORD_W != 32)
         $error("desc_verifier: WORD_W must be 32");
      if (NUM_WORDS < W_TIME + 2)
         $error("desc_verifier: NUM_WORDS too small for the field layout");
      if (SIZE_W + STRIDE_W != WORD_W)
         $error("desc_verifier: SIZE_W + STRIDE_W must fill one word");
   end

   logic              final_word;
   logic [WORD_W-1:0] ctrl_w, geom_w, time_w;
   logic              csum_match;
   desc_err_e         err_c;
   logic              last_c, wb_req_c;
   logic [WORD_W-1:0] status_c, wb_word_c;
   logic [SIZE_W-1:0] size_c;
   logic [STRIDE_OUT_W-1:0] stride_c;
   logic              take;

   desc_word_track #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_track (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .final_word(final_word), .ctrl_q(ctrl_w), .geom_q(geom_w), .time_q(time_w)
   );

   desc_csum_acc #(.WORD_W(WORD_W), .CSUM_EN(CSUM_EN)) u_csum (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .final_word(final_word), .csum_match(csum_match)
   );

   desc_judge #(
      .WORD_W(WORD_W), .SIZE_W(SIZE_W), .STRIDE_W(STRIDE_W),
      .STRIDE_SHIFT(STRIDE_SHIFT), .PREAMBLE(PREAMBLE)
   ) u_judge (
      .ctrl(ctrl_w), .geom(geom_w), .stamp(time_w), .csum_match(csum_match),
      .err(err_c), .last(last_c), .status(status_c), .line_size(size_c),
      .stride(stride_c), .wb_req(wb_req_c), .wb_word(wb_word_c)
   );

   assign take = in_valid && final_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
      end else begin
         res_valid <= take;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_err       <= '0;
         res_last      <= 1'b0;
         res_status    <= '0;
         res_line_size <= '0;
         res_stride    <= '0;
         res_wb_req    <= 1'b0;
         res_wb_word   <= '0;
      end else if (take) begin
         res_err       <= err_c;
         res_last      <= last_c;
         res_status    <= status_c;
         res_line_size <= size_c;
         res_stride    <= stride_c;
         res_wb_req    <= wb_req_c;
         res_wb_word   <= wb_word_c;
      end
   end
endmodule

// File: rtl/desc_verifier_sva.sv
module desc_verifier_sva #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 16,
   parameter int SIZE_W    = 18,
   parameter int STRIDE_OUT_W = 18
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [WORD_W-1:0]       in_word,
   input logic                    res_valid,
   input logic [1:0]              res_err,
   input logic                    res_last,
   input logic [WORD_W-1:0]       res_status,
   input logic [SIZE_W-1:0]       res_line_size,
   input logic [STRIDE_OUT_W-1:0] res_stride,
   input logic                    res_wb_req,
   input logic [WORD_W-1:0]       res_wb_word
);
   localparam int CW = $clog2(NUM_WORDS);
   logic [CW-1:0] seen_q;
   logic          closing;
   logic          unused_sva;

   assign closing    = in_valid && (seen_q == CW'(NUM_WORDS - 1));
   assign unused_sva = ^{in_word, res_line_size};

   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= '0;
      else if (in_valid) seen_q <= closing ? '0 : seen_q + 1'b1;
   end

   assert_pulse_on_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
      closing |=> res_valid);
   assert_no_stray_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !closing |=> !res_valid);
   assert_preamble_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_status[20:13] != 8'hA5) |-> res_err == 2'd1);
   assert_done_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_status[20:13] == 8'hA5 && res_err != 2'd2
       && res_status[10] && !res_status[9]) |-> res_err == 2'd3);
   assert_last_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_last == (res_status[7] | res_status[8]));
   assert_stride_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_stride[3:0] == 4'd0);
   assert_wb_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_wb_req |-> (res_status[11] && res_err == 2'd0 && res_wb_word[31]));
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable(res_status) && $stable(res_err) && $stable(res_wb_word));
endmodule

bind desc_verifier desc_verifier_sva #(
   .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SIZE_W(SIZE_W),
   .STRIDE_OUT_W(STRIDE_W + STRIDE_SHIFT)
) u_sva (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
   .res_valid(res_valid), .res_err(res_err), .res_last(res_last),
   .res_status(res_status), .res_line_size(res_line_size),
   .res_stride(res_stride), .res_wb_req(res_wb_req), .res_wb_word(res_wb_word)
);

// File: tb/test_desc_verifier.sv
module test_desc_verifier;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        res_valid, res_last, res_wb_req;
   logic [1:0]  res_err;
   logic [31:0] res_status, res_wb_word;
   logic [17:0] res_line_size, res_stride;

   int checks = 0;
   int errors = 0;
   logic [31:0] d [16];

   always #4 clk = ~clk;

   desc_verifier i_desc_verifier (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .res_valid(res_valid), .res_err(res_err), .res_last(res_last),
      .res_status(res_status), .res_line_size(res_line_size),
      .res_stride(res_stride), .res_wb_req(res_wb_req), .res_wb_word(res_wb_word)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sum15();
      logic [31:0] s = '0;
      for (int i = 0; i < 15; i++) s += d[i];
      return s;
   endfunction

   function automatic logic [1:0] exp_err();
      if (d[0][7:0] != 8'hA5) return 2'd1;
      if (d[0][20] && sum15() != d[15]) return 2'd2;
      if (d[5][31] && !d[0][10]) return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [31:0] exp_status();
      logic [31:0] s = '0;
      s[20:13] = d[0][7:0];
      s[4]  = d[0][11]; s[5]  = d[0][18]; s[6]  = d[0][20];
      s[7]  = d[0][19]; s[8]  = d[0][21]; s[9]  = d[0][10];
      s[10] = d[5][31]; s[11] = d[0][9];  s[12] = d[0][8];
      return s;
   endfunction

   task automatic send(input bit gaps);
      logic [31:0] st_prev;
      for (int i = 0; i < 16; i++) begin
         if (gaps && ($urandom % 4 == 0)) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
         @(negedge clk);
         chk("R1 no pulse mid-descriptor", {31'd0, res_valid}, 32'd0);
         in_valid = 1'b1;
         in_word  = d[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = $urandom;
      chk("R1 pulse",              {31'd0, res_valid}, 32'd1);
      chk("R5 error code",         {30'd0, res_err}, {30'd0, exp_err()});
      chk("R6 last",               {31'd0, res_last}, {31'd0, d[0][19] | d[0][21]});
      chk("R7 line size",          {14'd0, res_line_size}, {14'd0, d[3][17:0]});
      chk("R7 stride",             {14'd0, res_stride}, {14'd0, d[3][31:18], 4'd0});
      chk("R8 status",             res_status, exp_status());
      chk("R9 wb req",             {31'd0, res_wb_req},
          {31'd0, d[0][9] && exp_err() == 2'd0});
      chk("R9 wb word",            res_wb_word, d[5] | 32'h8000_0000);
      st_prev = res_status;
      @(negedge clk);
      chk("R10 pulse ends",        {31'd0, res_valid}, 32'd0);
      chk("R10 status held",       res_status, st_prev);
   endtask

   task automatic build_rand();
      for (int i = 0; i < 16; i++) d[i] = $urandom;
      if ($urandom % 4 != 0) d[0][7:0] = 8'hA5;
      d[5][31] = ($urandom % 3 == 0);
      if (d[0][20] && ($urandom % 3 != 0)) d[15] = sum15();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset valid",  {31'd0, res_valid}, 32'd0);
      chk("R10 reset err",    {30'd0, res_err}, 32'd0);
      chk("R10 reset status", res_status, 32'd0);
      chk("R10 reset wb",     res_wb_word, 32'd0);

      // R3: checksum passes although the sum wraps past 32 bits
      for (int i = 0; i < 16; i++) d[i] = 32'hFFFF_FFF0 - i;
      d[0] = 32'h0010_02A5; d[5] = 32'h0000_1234;
      d[15] = sum15();
      send(1'b0);
      // R5: every check fails, preamble wins
      d[0] = 32'h0010_0000; d[5] = 32'h8000_0000; d[15] = ~sum15();
      send(1'b0);
      // R5: checksum beats done
      d[0] = 32'h0010_00A5;
      send(1'b0);
      // R3 + R4: checksum off ignores word 15, ignore bit masks done flag
      d[0] = 32'h0028_06A5; d[15] = 32'hDEAD_BEEF;
      send(1'b0);
      // R4: done flag with ignore clear
      d[0] = 32'h0008_02A5;
      send(1'b1);
      // R2: preamble off by one bit
      d[0] = 32'h0000_00A4; d[5] = 32'h0;
      send(1'b0);

      for (int n = 0; n < 80; n++) begin
         build_rand();
         send(n % 2 == 1);
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule